// File: doc/BRIEF.md
# Dithered Dual-Modulus Fractional Tick Divider

This block turns a stream of reference enable pulses into an output tick whose average spacing is a fractional number of reference pulses. Each output period is either N or N+1 enables long. A five-bit error accumulator picks the length of each period. The long-term ratio is therefore N + k/32, where k is the programmed fraction numerator. Individual periods jitter by one enable, and that is acceptable because only the average rate matters.

At every period boundary the accumulator adds the numerator once. When the addition carries out, the period that begins there is one enable longer. The integer divisor and the numerator are sampled only at that boundary. A change written in the middle of a period therefore waits for the next boundary. A second output tells the consumer whether the period that has just finished was the long one.

Top module: `frac_tick_divider`

## Requirements
- R1: While reset is asserted, and after it is released until the first full period has been counted, `tick_o` and `long_o` are 0.
- R2: Each period contains exactly M enable pulses. `tick_o` is a one-cycle pulse in the clock cycle that follows the edge clocking the M-th enable. Reset starts a new period.
- R3: M is always either N or N+1. When the fraction numerator is 0, every period has length N.
- R4: The accumulator starts at 0 after reset. For each period, in order, it forms acc+k as a 6-bit sum. Bit 5 of that sum set means the period is N+1 long, and the low 5 bits become the new acc. With k held constant, exactly k of any 32 consecutive periods from reset are long, and the first period is short.
- R5: `long_o` is 1 exactly when the period ending at the current tick had length N+1. It changes only in a cycle where `tick_o` is 1 and otherwise holds its value.
- R6: `div_int` and `div_frac` are sampled at the edge that starts a period: the first enable after reset, or the last enable of the previous period. A change in the middle of a period does not alter the length of that period.
- R7: Clock cycles with `ref_en` low are not counted and never produce a tick.
- R8: A `div_int` value below 2 is treated as 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_en | input | 1 | Reference enable; each high cycle is one count |
| div_int | input | DIV_W | Integer divisor N |
| div_frac | input | FRAC_W | Fraction numerator k (units of 1/32) |
| tick_o | output | 1 | One-cycle pulse at the end of each period |
| long_o | output | 1 | 1 when the period just ended was N+1 long |

## Verification
The hardest situation to reach from the ports is an input change landing strictly inside a period, together with the accumulator being at a known value when the next boundary samples the new fraction. The bench reaches it by driving the enable stream itself and counting enables per period. It rewrites the divisor and the numerator in the middle of a period right after reset, which holds the accumulator at a known value. It then checks that the current period keeps the old length and that the following periods follow the accumulator sequence built from the new fraction. Gapped enable patterns show that idle cycles advance nothing.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;
  // Smallest usable integer divisor; smaller settings are raised to it.
  localparam int unsigned MIN_DIV = 2;
  // Number of fractional steps per unit of divisor.
  localparam int unsigned FRAC_STEPS = 32;
endpackage

// File: rtl/frac_rst_sync.sv
module frac_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/frac_phase_acc.sv
module frac_phase_acc #(
  parameter int unsigned FRAC_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic [FRAC_W-1:0] frac,
  output logic              carry,
  output logic [FRAC_W-1:0] acc_q
);
  logic [FRAC_W:0]   sum;
  logic [FRAC_W-1:0] acc_d;

  always_comb begin
    sum   = {1'b0, acc_q} + {1'b0, frac};
    carry = sum[FRAC_W];
    acc_d = acc_q;
    if (step_en) acc_d = sum[FRAC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end
endmodule

// File: rtl/frac_period_cnt.sv
module frac_period_cnt
  import frac_div_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_en,
  input  logic [DIV_W-1:0] div_int,
  input  logic             carry,
  output logic             start,
  output logic             period_end,
  output logic             cur_long_q
);
  localparam int unsigned CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] remain_q, remain_d;
  logic [CNT_W-1:0] n_eff, modulus;
  logic             empty, last, cur_long_d;

  always_comb begin
    n_eff = {1'b0, div_int};
    if (n_eff < CNT_W'(MIN_DIV)) n_eff = CNT_W'(MIN_DIV);
    modulus    = n_eff + CNT_W'(carry);
    empty      = (remain_q == '0);
    last       = (remain_q == CNT_W'(1));
    start      = ref_en && (empty || last);
    period_end = ref_en && last;
    remain_d   = remain_q;
    cur_long_d = cur_long_q;
    if (start) begin
      // An empty counter means this enable already belongs to the new period.
      remain_d   = empty ? (modulus - CNT_W'(1)) : modulus;
      cur_long_d = carry;
    end else if (ref_en) begin
      remain_d   = remain_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q   <= '0;
      cur_long_q <= 1'b0;
    end else begin
      remain_q   <= remain_d;
      cur_long_q <= cur_long_d;
    end
  end
endmodule

// File: rtl/frac_tick_out.sv
module frac_tick_out (
  input  logic clk,
  input  logic rst_n,
  input  logic period_end,
  input  logic cur_long,
  output logic tick_q,
  output logic long_q
);
  logic long_d;

  always_comb begin
    long_d = long_q;
    if (period_end) long_d = cur_long;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= 1'b0;
      long_q <= 1'b0;
    end else begin
      tick_q <= period_end;
      long_q <= long_d;
    end
  end
endmodule

// File: rtl/frac_tick_divider.sv
module frac_tick_divider #(
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned FRAC_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_en,
  input  logic [DIV_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] div_frac,
  output logic              tick_o,
  output logic              long_o
);
  logic              rst_i_n;
  logic              start, period_end, carry, cur_long;
  logic [FRAC_W-1:0] acc_q;

  frac_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  frac_phase_acc #(.FRAC_W(FRAC_W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .step_en (start),
    .frac    (div_frac),
    .carry   (carry),
    .acc_q   (acc_q)
  );

  frac_period_cnt #(.DIV_W(DIV_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .ref_en     (ref_en),
    .div_int    (div_int),
    .carry      (carry),
    .start      (start),
    .period_end (period_end),
    .cur_long_q (cur_long)
  );

  frac_tick_out u_out (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .period_end (period_end),
    .cur_long   (cur_long),
    .tick_q     (tick_o),
    .long_q     (long_o)
  );
endmodule

// File: rtl/frac_tick_divider_chk.sv
module frac_tick_divider_chk #(
  parameter int unsigned FRAC_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ref_en,
  input logic              tick_o,
  input logic              long_o,
  input logic [FRAC_W-1:0] acc_q
);
  // R2: the tick lasts one cycle, since a period holds at least two enables
  assert_tick_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);

  // R7: a tick always follows a cycle in which an enable was counted
  assert_tick_needs_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> $past(ref_en));

  // R5: the long flag moves only together with a tick
  assert_long_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(long_o) |-> tick_o);

  // R4: the accumulator advances only on a counted enable
  assert_acc_on_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(acc_q) |-> $past(ref_en));
endmodule

bind frac_tick_divider frac_tick_divider_chk #(.FRAC_W(FRAC_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .ref_en (ref_en),
  .tick_o (tick_o),
  .long_o (long_o),
  .acc_q  (acc_q)
);

// File: tb/frac_tick_divider_bench.sv
module frac_tick_divider_bench;
  localparam int DIV_W  = 8;
  localparam int FRAC_W = 5;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              ref_en;
  logic [DIV_W-1:0]  div_int;
  logic [FRAC_W-1:0] div_frac;
  logic              tick_o, long_o;

  int nchk = 0;
  int nfail = 0;
  int m_acc;
  int exp_m;
  bit exp_l;

  always #4 clk = ~clk;

  frac_tick_divider #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_frac_tick_divider (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .div_int(div_int),
    .div_frac(div_frac), .tick_o(tick_o), .long_o(long_o)
  );

  // Each vector: {N[15:8], k[7:3], enable gap[2:0]}
  localparam logic [15:0] VEC [9] = '{
    {8'd16,  5'd0,  3'd0}, {8'd16, 5'd1,  3'd0}, {8'd16, 5'd16, 3'd1},
    {8'd16,  5'd31, 3'd0}, {8'd5,  5'd7,  3'd2}, {8'd3,  5'd13, 3'd0},
    {8'd0,   5'd5,  3'd0}, {8'd1,  5'd31, 3'd3}, {8'd255, 5'd3, 3'd0}
  };

  task automatic check(input bit ok, input string req, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // Model of the next period from the inputs at the boundary (R4, R8).
  task automatic model_next();
    int n;
    int s;
    n = (int'(div_int) < 2) ? 2 : int'(div_int);
    s = m_acc + int'(div_frac);
    exp_l = (s >= 32);
    m_acc = s % 32;
    exp_m = n + (exp_l ? 1 : 0);
  endtask

  task automatic do_reset();
    ref_en = 1'b0;
    rst_n  = 1'b0;
    repeat (3) @(negedge clk);
    check(tick_o == 1'b0 && long_o == 1'b0, "R1 reset", {tick_o, long_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_acc = 0;
  endtask

  // Run one period: count enables until the tick; optionally change inputs.
  task automatic one_period(input int gap, input int chg_at,
                            input logic [DIV_W-1:0] cn, input logic [FRAC_W-1:0] cf);
    int cnt;
    int phase;
    bit done;
    cnt = 0;
    phase = 0;
    done = 0;
    for (int g = 0; g < 3000 && !done; g++) begin
      @(negedge clk);
      if (tick_o) begin
        check(cnt == exp_m, "R2 period length", cnt, exp_m);
        check(long_o == exp_l, "R5 long flag", long_o, exp_l);
        ref_en = 1'b0;
        done = 1;
      end else begin
        ref_en = (phase == 0);
        phase = (phase == gap) ? 0 : phase + 1;
        if (ref_en) cnt++;
        if (cnt == chg_at && ref_en) begin
          div_int  = cn;
          div_frac = cf;
        end
      end
    end
    if (!done) check(1'b0, "R2 no tick", cnt, exp_m);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    ref_en = 1'b0; div_int = 8'd4; div_frac = '0;
    do_reset();

    // R1, R7: idle enable produces no tick
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      check(tick_o == 1'b0, "R7 idle no tick", tick_o, 0);
    end

    // Table walk: R3, R4, R8 over 32 periods per vector
    foreach (VEC[v]) begin
      int longs;
      div_int  = VEC[v][15:8];
      div_frac = VEC[v][7:3];
      do_reset();
      longs = 0;
      for (int p = 0; p < 32; p++) begin
        model_next();
        if (p == 0) check(exp_l == 1'b0, "R4 first period short", exp_l, 0);
        if (exp_l) longs++;
        one_period(int'(VEC[v][2:0]), -1, '0, '0);
      end
      check(longs == int'(VEC[v][7:3]), "R4 long count", longs, int'(VEC[v][7:3]));
      if (VEC[v][7:3] == 0) check(longs == 0, "R3 zero fraction", longs, 0);
    end

    // R6: change inputs mid-period; the current period keeps old length
    div_int = 8'd10; div_frac = 5'd0;
    do_reset();
    model_next();
    one_period(0, 3, 8'd6, 5'd16);
    for (int p = 0; p < 4; p++) begin
      model_next();
      one_period(1, -1, '0, '0);
    end
    check(m_acc == 0, "R6 accumulator model after change", m_acc, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule